// File: doc/BRIEF.md
# Per-Activation Transfer Sequencer

This block performs the data movement of one activation of a descriptor-driven transfer engine. A fetch stage outside the block hands over the working register values (source address, destination address, two 16-bit counts and the mode settings) with a one-cycle `start` pulse. The block moves items through a read beat followed by a write beat on a valid/ready memory port. Each item is 8, 16 or 32 bits wide. After each item the two addresses are stepped and the counters are updated by the rules of the selected counting scheme. When the activation ends, the block pulses `done` for one cycle. On that cycle the updated register values are presented for write-back, along with the interrupt-request, completion and bus-error flags.

Three counting schemes are offered. In normal mode one item moves per activation against a 16-bit down-count. In repeat mode one item moves per activation inside a repeating window; the window's address side is brought back to its start each time the running count runs out. In block mode a whole block moves per activation; the block side's address is rewound after every block and a separate block count is decremented.

The memory port follows valid/ready rules. `mem_valid` rises with address, direction, size and write data. All of these stay stable until a cycle in which `mem_ready` is high, and that cycle completes the beat. The memory may hold `mem_ready` low for any number of cycles to apply back-pressure. Only one beat is ever outstanding. `mem_err` is looked at only in a cycle where `mem_ready` is high.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `mem_valid` are low.
- R2: `cfg_size` picks the item width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. `mem_size` carries the same code (3 shown as 2). The write data equals the read data with the bits above the item width cleared. The address step is 1, 2 or 4 bytes to match.
- R3: Each of `cfg_src_step` and `cfg_dst_step` is applied after every item on its own side: 00 and 11 leave the address unchanged, 01 adds the step, 10 subtracts it.
- R4: Normal mode (`cfg_mode` 00) moves exactly one item per activation and returns count A reduced by one modulo 65536. A loaded count of 0 comes back as 65535.
- R5: Repeat mode (`cfg_mode` 01) moves one item per activation and decrements the low byte of count A. When that byte reaches 0, it is reloaded from the high byte, and the address of the window side is moved back by N items (N = high byte, 0 meaning 256). Count B is unchanged.
- R6: Repeat mode never raises `irq_req` or `complete`.
- R7: Block mode (`cfg_mode` 10) moves items until the low byte of count A reaches 0, which is a block of N items when the low byte starts equal to the high byte (0 meaning 256). It then reloads the low byte from the high byte, decrements count B by one, and rewinds the block side by N items. The other side keeps its accumulated address.
- R8: With `cfg_irq_each` set, `irq_req` is raised after every normal-mode item and every completed block. Otherwise `irq_req` and `complete` are raised only when the governing count (A in normal mode, B in block mode) goes from 1 to 0. `complete` is raised exactly in that case.
- R9: `cfg_area_dst` = 1 makes the destination the repeat/block side; 0 makes it the source.
- R10: Every item is a read beat at the source address followed by a write beat at the destination address. Address and direction stay stable while `mem_valid` is high without `mem_ready`.
- R11: `done` is a single-cycle pulse. On it the write-back outputs hold the updated registers.
- R12: A beat that ends with `mem_err` stops the activation at once and sets `bus_err` on `done`. The write-back registers keep the values after the last completed item, and neither `irq_req` nor `complete` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an activation when idle |
| cfg_mode | input | 2 | 00 normal, 01 repeat, 10 block |
| cfg_size | input | 2 | Item width code |
| cfg_src_step | input | 2 | Source address rule |
| cfg_dst_step | input | 2 | Destination address rule |
| cfg_area_dst | input | 1 | Repeat/block side is the destination |
| cfg_irq_each | input | 1 | Interrupt after every item or block |
| ld_src | input | AW | Loaded source address |
| ld_dst | input | AW | Loaded destination address |
| ld_cnt_a | input | 16 | Loaded count A |
| ld_cnt_b | input | 16 | Loaded count B |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle end of activation |
| wb_src | output | AW | Updated source address |
| wb_dst | output | AW | Updated destination address |
| wb_cnt_a | output | 16 | Updated count A |
| wb_cnt_b | output | 16 | Updated count B |
| irq_req | output | 1 | Interrupt request, valid with done |
| complete | output | 1 | Final count reached, valid with done |
| bus_err | output | 1 | Activation stopped by bus error, valid with done |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | Beat width code |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_err | input | 1 | Error response, qualified by mem_ready |

## Verification
Chains of activations are run with each activation's write-back fed into the next, so repeat windows wrap and block counts reach their final value. Every beat on the memory port is compared with a reference model. Random mixes of width codes, step rules and side selection separate increment from decrement and fixed, and source-side from destination-side rewinds. The random mixes also catch a wrong step size, because a wrong size shifts the very first stepped address. Directed cases cover a zero normal count (65536 wrap), a 256-item block from a zero high byte, interrupt-per-block against interrupt-at-end, and bus errors on a read beat and on a write beat. The bus-error cases show whether the registers stop at the last completed item. Random ready delays vary the back-pressure on the port.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_HOLD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
  import xfer_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic [AW-1:0]      addr_i,
  input  addr_mode_e         mode_i,
  input  logic [1:0]         size_i,
  input  logic               rewind_i,
  input  logic [CNT_W/2-1:0] area_n_i,
  output logic [AW-1:0]      addr_o
);
  localparam int HW = CNT_W / 2;

  logic [AW-1:0] step;
  logic [AW-1:0] span;
  logic [AW-1:0] adv;
  logic [HW:0]   n_items;

  always_comb begin
    step    = AW'(1) << size_i;
    n_items = (area_n_i == '0) ? {1'b1, {HW{1'b0}}} : {1'b0, area_n_i};
    span    = AW'(n_items) << size_i;
    case (mode_i)
      AM_INC:  adv = addr_i + step;
      AM_DEC:  adv = addr_i - step;
      default: adv = addr_i;
    endcase
    addr_o = adv;
    if (rewind_i) begin
      case (mode_i)
        AM_INC:  addr_o = adv - span;
        AM_DEC:  addr_o = adv + span;
        default: addr_o = adv;
      endcase
    end
  end
endmodule

// File: rtl/xfer_count_step.sv
module xfer_count_step
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  xfer_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_a_i,
  input  logic [CNT_W-1:0] cnt_b_i,
  input  logic             irq_each_i,
  output logic [CNT_W-1:0] cnt_a_o,
  output logic [CNT_W-1:0] cnt_b_o,
  output logic             wrap_o,
  output logic             last_o,
  output logic             final_o,
  output logic             irq_o
);
  localparam int HW = CNT_W / 2;

  logic [HW-1:0] lo_dec;
  logic [HW-1:0] hi;
  logic          hit;

  always_comb begin
    hi      = cnt_a_i[CNT_W-1:HW];
    lo_dec  = cnt_a_i[HW-1:0] - HW'(1);
    hit     = (lo_dec == '0);
    cnt_a_o = cnt_a_i - CNT_W'(1);
    cnt_b_o = cnt_b_i;
    wrap_o  = 1'b0;
    last_o  = 1'b1;
    final_o = 1'b0;
    irq_o   = 1'b0;
    case (mode_i)
      XM_REPEAT: begin
        wrap_o  = hit;
        cnt_a_o = {hi, hit ? hi : lo_dec};
      end
      XM_BLOCK: begin
        wrap_o  = hit;
        last_o  = hit;
        cnt_a_o = {hi, hit ? hi : lo_dec};
        final_o = hit && (cnt_b_i == CNT_W'(1));
        cnt_b_o = hit ? cnt_b_i - CNT_W'(1) : cnt_b_i;
        irq_o   = hit && (irq_each_i || final_o);
      end
      default: begin
        final_o = (cnt_a_i == CNT_W'(1));
        irq_o   = irq_each_i || final_o;
      end
    endcase
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_size,
  input  logic [1:0]       cfg_src_step,
  input  logic [1:0]       cfg_dst_step,
  input  logic             cfg_area_dst,
  input  logic             cfg_irq_each,
  input  logic [AW-1:0]    ld_src,
  input  logic [AW-1:0]    ld_dst,
  input  logic [CNT_W-1:0] ld_cnt_a,
  input  logic [CNT_W-1:0] ld_cnt_b,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    wb_src,
  output logic [AW-1:0]    wb_dst,
  output logic [CNT_W-1:0] wb_cnt_a,
  output logic [CNT_W-1:0] wb_cnt_b,
  output logic             irq_req,
  output logic             complete,
  output logic             bus_err,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [1:0]       mem_size,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err
);
  localparam int HW = CNT_W / 2;
  localparam int DW = 32;

  seq_state_e       state;
  xfer_mode_e       mode_q;
  addr_mode_e       amode_q [2];
  logic [1:0]       size_q;
  logic             area_dst_q;
  logic             each_q;
  logic [AW-1:0]    side_q  [2];
  logic [AW-1:0]    side_nx [2];
  logic [CNT_W-1:0] cnt_a_q, cnt_b_q, cnt_a_nx, cnt_b_nx;
  logic [DW-1:0]    data_q, data_mask;
  logic             wrap, last_item, final_hit, irq_hit;
  logic             irq_r, cmp_r, err_r;

  xfer_count_step #(.CNT_W(CNT_W)) u_count (
    .mode_i    (mode_q),
    .cnt_a_i   (cnt_a_q),
    .cnt_b_i   (cnt_b_q),
    .irq_each_i(each_q),
    .cnt_a_o   (cnt_a_nx),
    .cnt_b_o   (cnt_b_nx),
    .wrap_o    (wrap),
    .last_o    (last_item),
    .final_o   (final_hit),
    .irq_o     (irq_hit)
  );

  // Index 0 is the source side, index 1 the destination side.
  for (genvar g = 0; g < 2; g++) begin : g_side
    xfer_addr_step #(.AW(AW), .CNT_W(CNT_W)) u_step (
      .addr_i  (side_q[g]),
      .mode_i  (amode_q[g]),
      .size_i  (size_q),
      .rewind_i(wrap && (area_dst_q == 1'(g))),
      .area_n_i(cnt_a_q[CNT_W-1:HW]),
      .addr_o  (side_nx[g])
    );
  end

  always_comb begin
    case (size_q)
      2'd0:    data_mask = DW'(8'hFF);
      2'd1:    data_mask = DW'(16'hFFFF);
      default: data_mask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= XM_NORMAL;
      amode_q[0] <= AM_FIXED;
      amode_q[1] <= AM_FIXED;
      size_q     <= '0;
      area_dst_q <= 1'b0;
      each_q     <= 1'b0;
      side_q[0]  <= '0;
      side_q[1]  <= '0;
      cnt_a_q    <= '0;
      cnt_b_q    <= '0;
      data_q     <= '0;
      irq_r      <= 1'b0;
      cmp_r      <= 1'b0;
      err_r      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q     <= xfer_mode_e'(cfg_mode);
            amode_q[0] <= addr_mode_e'(cfg_src_step);
            amode_q[1] <= addr_mode_e'(cfg_dst_step);
            size_q     <= (cfg_size == 2'd3) ? 2'd2 : cfg_size;
            area_dst_q <= cfg_area_dst;
            each_q     <= cfg_irq_each;
            side_q[0]  <= ld_src;
            side_q[1]  <= ld_dst;
            cnt_a_q    <= ld_cnt_a;
            cnt_b_q    <= ld_cnt_b;
            irq_r      <= 1'b0;
            cmp_r      <= 1'b0;
            err_r      <= 1'b0;
            state      <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            if (mem_err) begin
              err_r <= 1'b1;
              state <= ST_FIN;
            end else begin
              data_q <= mem_rdata & data_mask;
              state  <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            if (mem_err) begin
              err_r <= 1'b1;
              state <= ST_FIN;
            end else begin
              side_q[0] <= side_nx[0];
              side_q[1] <= side_nx[1];
              cnt_a_q   <= cnt_a_nx;
              cnt_b_q   <= cnt_b_nx;
              if (last_item) begin
                irq_r <= irq_hit;
                cmp_r <= final_hit;
                state <= ST_FIN;
              end else begin
                state <= ST_RD;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign wb_src    = side_q[0];
  assign wb_dst    = side_q[1];
  assign wb_cnt_a  = cnt_a_q;
  assign wb_cnt_b  = cnt_b_q;
  assign irq_req   = irq_r;
  assign complete  = cmp_r;
  assign bus_err   = err_r;
  assign mem_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_size  = size_q;
  assign mem_addr  = (state == ST_WR) ? side_q[1] : side_q[0];
  assign mem_wdata = data_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          irq_req,
  input logic          complete,
  input logic          bus_err,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mode_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_repeat_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == 2'b01) |-> !irq_req && !complete);

  assert_final_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && complete |-> irq_req);

  assert_err_noflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done && bus_err |-> !complete && !irq_req);
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .irq_req  (irq_req),
  .complete (complete),
  .bus_err  (bus_err),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mode_q   (mode_q)
);

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  c_mode = 0, c_size = 0, c_smode = 0, c_dmode = 0;
  logic        c_adst = 0, c_each = 0;
  logic [31:0] i_src = 0, i_dst = 0;
  logic [15:0] i_a = 0, i_b = 0;
  logic        busy, done, irq_req, complete, bus_err;
  logic [31:0] wb_src, wb_dst;
  logic [15:0] wb_cnt_a, wb_cnt_b;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;

  always #10 clk = ~clk;

  xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_mode(c_mode), .cfg_size(c_size), .cfg_src_step(c_smode),
    .cfg_dst_step(c_dmode), .cfg_area_dst(c_adst), .cfg_irq_each(c_each),
    .ld_src(i_src), .ld_dst(i_dst), .ld_cnt_a(i_a), .ld_cnt_b(i_b),
    .busy(busy), .done(done), .wb_src(wb_src), .wb_dst(wb_dst),
    .wb_cnt_a(wb_cnt_a), .wb_cnt_b(wb_cnt_b), .irq_req(irq_req),
    .complete(complete), .bus_err(bus_err), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err)
  );

  int nchk = 0, nerr = 0;
  bit hung = 0;
  int err_idx = -1;
  int got_n = 0, exp_n = 0, dly = 0;
  logic [31:0] got_addr [0:599], got_data [0:599], exp_addr [0:599], exp_data [0:599];
  logic [1:0]  got_size [0:599];
  logic        got_we [0:599], exp_we [0:599];
  logic [31:0] e_src, e_dst;
  logic [15:0] e_a, e_b;
  logic        e_irq, e_cmp, e_err;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] m, input int sz);
    if (m == 2'b01) return a + (32'd1 << sz);
    if (m == 2'b10) return a - (32'd1 << sz);
    return a;
  endfunction

  function automatic logic [31:0] rew(input logic [31:0] a, input logic [1:0] m, input int sz,
                                      input logic [7:0] hi);
    int nn = (hi == 0) ? 256 : int'(hi);
    if (m == 2'b01) return a - (32'(nn) << sz);
    if (m == 2'b10) return a + (32'(nn) << sz);
    return a;
  endfunction

  // Memory model: random ready delay, read data from address pattern, logs every beat.
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      mem_err   <= 1'b0;
    end else if (mem_valid) begin
      if (dly == 0) begin
        mem_ready <= 1'b1;
        mem_err   <= (got_n == err_idx);
        mem_rdata <= pat(mem_addr);
        if (got_n < 600) begin
          got_addr[got_n] = mem_addr;
          got_we[got_n]   = mem_we;
          got_data[got_n] = mem_wdata;
          got_size[got_n] = mem_size;
        end
        got_n = got_n + 1;
        dly = int'($urandom % 3);
      end else begin
        dly = dly - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input int err_at);
    logic [31:0] s = i_src, d = i_dst;
    logic [15:0] a = i_a, b = i_b;
    logic [7:0]  lo;
    logic [31:0] msk;
    int n = 0;
    int sz = (c_size == 2'd3) ? 2 : int'(c_size);
    bit stop = 0;
    msk = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    e_irq = 0; e_cmp = 0; e_err = 0;
    while (!stop) begin
      exp_addr[n] = s; exp_we[n] = 0; exp_data[n] = 0; n++;
      if (err_at == n - 1) begin e_err = 1; break; end
      exp_addr[n] = d; exp_we[n] = 1; exp_data[n] = pat(s) & msk; n++;
      if (err_at == n - 1) begin e_err = 1; break; end
      s = adv(s, c_smode, sz);
      d = adv(d, c_dmode, sz);
      if (c_mode == 2'b01) begin
        lo = a[7:0] - 8'd1;
        if (lo == 0) begin
          if (c_adst) d = rew(d, c_dmode, sz, a[15:8]);
          else        s = rew(s, c_smode, sz, a[15:8]);
          lo = a[15:8];
        end
        a = {a[15:8], lo};
        stop = 1;
      end else if (c_mode == 2'b10) begin
        lo = a[7:0] - 8'd1;
        if (lo == 0) begin
          if (c_adst) d = rew(d, c_dmode, sz, a[15:8]);
          else        s = rew(s, c_smode, sz, a[15:8]);
          lo = a[15:8];
          e_cmp = (b == 16'd1);
          b = b - 16'd1;
          e_irq = c_each || e_cmp;
          stop = 1;
        end
        a = {a[15:8], lo};
      end else begin
        e_cmp = (a == 16'd1);
        a = a - 16'd1;
        e_irq = c_each || e_cmp;
        stop = 1;
      end
    end
    exp_n = n;
    e_src = s; e_dst = d; e_a = a; e_b = b;
  endtask

  task automatic run_act(input int err_at);
    int t = 0;
    int lim;
    string ctag, atag, itag;
    int sz;
    if (hung) return;
    model(err_at);
    sz = (c_size == 2'd3) ? 2 : int'(c_size);
    @(negedge clk);
    err_idx = err_at;
    got_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      chk(0, "R11", "watchdog: no done", 32'(t), 32'd0);
      hung = 1;
      return;
    end
    ctag = (c_mode == 2'b01) ? "R5" : (c_mode == 2'b10) ? "R7" : "R4";
    atag = (c_mode == 2'b00 || c_mode == 2'b11) ? "R3" : "R9";
    itag = (c_mode == 2'b01) ? "R6" : "R8";
    chk(got_n == exp_n, "R10", "beat count", 32'(got_n), 32'(exp_n));
    lim = (got_n < exp_n) ? got_n : exp_n;
    if (lim > 600) lim = 600;
    for (int i = 0; i < lim; i++) begin
      if (got_addr[i] !== exp_addr[i] || got_we[i] !== exp_we[i])
        chk(0, (got_we[i] !== exp_we[i]) ? "R10" : "R3", "beat address/direction",
            got_addr[i], exp_addr[i]);
      else if (exp_we[i] && got_data[i] !== exp_data[i])
        chk(0, "R2", "write data", got_data[i], exp_data[i]);
      else if (got_size[i] !== 2'(sz))
        chk(0, "R2", "beat size", 32'(got_size[i]), 32'(sz));
      else
        chk(1, "R10", "beat", 0, 0);
    end
    chk(wb_src === e_src, e_err ? "R12" : atag, "wb_src", wb_src, e_src);
    chk(wb_dst === e_dst, e_err ? "R12" : atag, "wb_dst", wb_dst, e_dst);
    chk(wb_cnt_a === e_a, e_err ? "R12" : ctag, "wb_cnt_a", 32'(wb_cnt_a), 32'(e_a));
    chk(wb_cnt_b === e_b, e_err ? "R12" : ctag, "wb_cnt_b", 32'(wb_cnt_b), 32'(e_b));
    chk(irq_req === e_irq, itag, "irq_req", 32'(irq_req), 32'(e_irq));
    chk(complete === e_cmp, itag, "complete", 32'(complete), 32'(e_cmp));
    chk(bus_err === e_err, "R12", "bus_err", 32'(bus_err), 32'(e_err));
    @(negedge clk);
    chk(done === 1'b0, "R11", "done single pulse", 32'(done), 0);
    i_src = e_src; i_dst = e_dst; i_a = e_a; i_b = e_b;
  endtask

  task automatic setcfg(input logic [1:0] m, input logic [1:0] sz, input logic [1:0] sm,
                        input logic [1:0] dm, input logic ad, input logic ea,
                        input logic [31:0] s, input logic [31:0] d,
                        input logic [15:0] a, input logic [15:0] b);
    c_mode = m; c_size = sz; c_smode = sm; c_dmode = dm; c_adst = ad; c_each = ea;
    i_src = s; i_dst = d; i_a = a; i_b = b;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
    chk(mem_valid === 1'b0, "R1", "mem_valid in reset", 32'(mem_valid), 0);
    chk(done === 1'b0, "R1", "done in reset", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_valid === 1'b0, "R1", "idle after reset", 32'(busy), 0);

    // R4: zero count wraps to 65535, no completion
    setcfg(2'b00, 2'd0, 2'b01, 2'b01, 0, 0, 32'h1000, 32'h2000, 16'h0000, 16'h0);
    run_act(-1);
    // R8: count 1 -> 0 completes
    setcfg(2'b00, 2'd1, 2'b10, 2'b00, 0, 0, 32'h1100, 32'h2100, 16'h0001, 16'h0);
    run_act(-1);
    // R5/R9: repeat window on source, then on destination with decrement
    setcfg(2'b01, 2'd1, 2'b01, 2'b00, 0, 1, 32'h3000, 32'h4000, 16'h0301, 16'h5);
    repeat (4) run_act(-1);
    setcfg(2'b01, 2'd2, 2'b00, 2'b10, 1, 0, 32'h3100, 32'h4100, 16'h0202, 16'h0);
    repeat (5) run_act(-1);
    // R7: 256-item block from zero high byte, final block
    setcfg(2'b10, 2'd2, 2'b01, 2'b01, 1, 0, 32'h5000, 32'h6000, 16'h0000, 16'h1);
    run_act(-1);
    // R8: interrupt per block, block side destination decrementing
    setcfg(2'b10, 2'd0, 2'b01, 2'b10, 1, 1, 32'h7000, 32'h8000, 16'h0202, 16'h2);
    repeat (2) run_act(-1);
    // R12: error on a write beat and on a later read beat
    setcfg(2'b00, 2'd2, 2'b01, 2'b01, 0, 1, 32'h9000, 32'hA000, 16'h0004, 16'h0);
    run_act(1);
    setcfg(2'b10, 2'd1, 2'b01, 2'b01, 0, 0, 32'hB000, 32'hC000, 16'h0303, 16'h2);
    run_act(2);

    // Random chains
    for (int ch = 0; ch < 15; ch++) begin
      logic [7:0] hi;
      logic [1:0] m;
      m  = 2'($urandom % 3);
      hi = 8'(1 + $urandom % 5);
      setcfg(m, 2'($urandom % 4), 2'($urandom % 4), 2'($urandom % 4),
             1'($urandom % 2), 1'($urandom % 2),
             32'h0001_0000 + ($urandom % 32'h100) * 4, 32'h0002_0000 + ($urandom % 32'h100) * 4,
             (m == 2'b00) ? 16'(1 + $urandom % 3) : {hi, 8'(1 + $urandom % hi)},
             16'(1 + $urandom % 3));
      for (int k = 0; k < 4; k++)
        run_act(($urandom % 8 == 0) ? int'($urandom % 4) : -1);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule